// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block chooses the program counter that follows a control-flow instruction in a small 8-bit microcontroller core, and reports how many clock cycles that instruction occupies. The decoder presents a control class together with the current PC and a raw offset field. It also presents the 8-bit status register, a status-bit selector, the outcome of a compare or bit test already made elsewhere, the 16-bit indirect pointer, the return address popped by the stack logic, and a flag telling whether the instruction after the current one is two words long.

The block covers eight kinds of control flow. Plain sequential flow advances by one word. Relative jumps and calls add a sign-extended 12-bit offset plus one. Indirect jumps and calls load the pointer. Conditional branches test one status bit for set or clear, or test the signed relation formed from the negative and overflow bits, and add a sign-extended 7-bit offset plus one when taken. Skips step over one or two words. Returns take the address that is handed in and, for an interrupt return, raise a request to set the global interrupt flag.

Results are registered. A pulse on the issue input loads the next PC, the cycle count and the interrupt-flag request, and the valid output marks the following cycle. Fetching memory and moving the stack pointer are left to neighbouring blocks.

Top module: `nextpc_unit`

## Requirements
- R1: Class code 0 (sequential) gives next PC = PC+1 with a cycle count of 1. All PC arithmetic wraps modulo 2^16, so PC 0xFFFF advances to 0x0000.
- R2: Class 1 (relative jump) and class 2 (relative call) give PC + sext(offsetRaw[11:0]) + 1, with cycle counts of 2 and 3.
- R3: Class 3 (indirect jump) and class 4 (indirect call) give next PC = zPtr, with cycle counts of 2 and 3.
- R4: Class 5 branches when statusReg[bitSel] is 1 and class 6 branches when it is 0. A taken branch gives PC + sext(offsetRaw[6:0]) + 1 in 2 cycles; offsetRaw[11:7] is ignored. A branch that is not taken gives PC+1 in 1 cycle.
- R5: The status bits are ordered I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. Class 7 (signed greater-or-equal) is taken when N XOR V is 0, and class 8 (signed less-than) is taken when N XOR V is 1. The stored S bit is not used. Taken and not-taken results follow R4.
- R6: Class 9 (skip) gives PC+1 in 1 cycle when cmpHit is 0. When cmpHit is 1 it gives PC+2 in 2 cycles if nextIsWide is 0, and PC+3 in 3 cycles if nextIsWide is 1.
- R7: Class 10 (return) and class 11 (interrupt return) give next PC = stackPc in 4 cycles. setIntFlag is 1 only for class 11.
- R8: The outputs update on the clock edge where issue is 1, and outValid is 1 in the following cycle. On an edge where issue is 0, outValid goes to 0 and nextPc, cycleCount and setIntFlag keep their values.
- R9: While rstN is low, nextPc, cycleCount, setIntFlag and outValid are all 0, whatever the inputs.
- R10: The unused class codes 12 to 15 behave as sequential flow (PC+1, 1 cycle).
- R11: nextIsWide has no effect on any class other than a skip whose cmpHit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Evaluate the presented instruction on this edge |
| ctrlClass | input | 4 | Control class code (see R1 to R10) |
| curPc | input | 16 | Word address of the current instruction |
| offsetRaw | input | 12 | Raw signed offset field |
| statusReg | input | 8 | Status register, I at bit 7 down to C at bit 0 |
| bitSel | input | 3 | Status bit tested by classes 5 and 6 |
| cmpHit | input | 1 | Skip condition already evaluated by the compare/bit-test logic |
| nextIsWide | input | 1 | Instruction after the current one is two words long |
| zPtr | input | 16 | Indirect target pointer |
| stackPc | input | 16 | Return address supplied by the stack logic |
| nextPc | output | 16 | Registered next program counter |
| cycleCount | output | 3 | Registered cycle count of the instruction |
| setIntFlag | output | 1 | Registered request to set the global interrupt flag |
| outValid | output | 1 | Outputs were loaded on the previous edge |

## Verification
Two decisions meet in one evaluation when a skip is taken: the compare outcome decides whether to skip at all, and the length flag of the following instruction decides the distance and the cost. The bench therefore drives every combination of cmpHit and nextIsWide on skips. It also sets nextIsWide on every other class to show that the flag only matters in that one case. Interrupt return likewise yields an address and a flag request in the same cycle. Back-to-back issues of returns and interrupt returns check that the request rises and falls with the class, and the behavioural model checks all four outputs together on every clock.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int SREG_W = 8;
  localparam int CYC_W  = 3;
  localparam int BIT_V  = 3;
  localparam int BIT_N  = 2;

  typedef enum logic [3:0] {
    CC_SEQ   = 4'd0,
    CC_RJMP  = 4'd1,
    CC_RCALL = 4'd2,
    CC_IJMP  = 4'd3,
    CC_ICALL = 4'd4,
    CC_BRSET = 4'd5,
    CC_BRCLR = 4'd6,
    CC_BRGE  = 4'd7,
    CC_BRLT  = 4'd8,
    CC_SKIP  = 4'd9,
    CC_RET   = 4'd10,
    CC_RETI  = 4'd11
  } ctrlClassE;

  typedef enum logic [2:0] {
    SRC_INC1  = 3'd0,
    SRC_INC2  = 3'd1,
    SRC_INC3  = 3'd2,
    SRC_JREL  = 3'd3,
    SRC_BREL  = 3'd4,
    SRC_PTR   = 3'd5,
    SRC_STACK = 3'd6
  } srcSelE;

  typedef struct packed {
    srcSelE             srcSel;
    logic [CYC_W-1:0]   cycles;
    logic               setI;
  } ctrlStrobesT;

endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
(
  input  logic [3:0]                   ctrlClass,
  input  logic [SREG_W-1:0]            statusReg,
  input  logic [$clog2(SREG_W)-1:0]    bitSel,
  input  logic                         cmpHit,
  input  logic                         nextIsWide,
  output ctrlStrobesT                  strobes
);

  ctrlClassE cls;
  logic      isBranch;
  logic      brTaken;
  logic      signedLess;

  assign cls        = ctrlClassE'(ctrlClass);
  assign signedLess = statusReg[BIT_N] ^ statusReg[BIT_V];

  // branch condition evaluation
  always_comb begin
    isBranch = 1'b1;
    brTaken  = 1'b0;
    case (cls)
      CC_BRSET: brTaken = statusReg[bitSel];
      CC_BRCLR: brTaken = ~statusReg[bitSel];
      CC_BRGE:  brTaken = ~signedLess;
      CC_BRLT:  brTaken = signedLess;
      default:  isBranch = 1'b0;
    endcase
  end

  // strobe generation
  always_comb begin
    strobes.srcSel = SRC_INC1;
    strobes.cycles = CYC_W'(1);
    strobes.setI   = 1'b0;
    if (isBranch) begin
      if (brTaken) begin
        strobes.srcSel = SRC_BREL;
        strobes.cycles = CYC_W'(2);
      end
    end else begin
      case (cls)
        CC_RJMP: begin
          strobes.srcSel = SRC_JREL;
          strobes.cycles = CYC_W'(2);
        end
        CC_RCALL: begin
          strobes.srcSel = SRC_JREL;
          strobes.cycles = CYC_W'(3);
        end
        CC_IJMP: begin
          strobes.srcSel = SRC_PTR;
          strobes.cycles = CYC_W'(2);
        end
        CC_ICALL: begin
          strobes.srcSel = SRC_PTR;
          strobes.cycles = CYC_W'(3);
        end
        CC_SKIP: begin
          if (cmpHit) begin
            strobes.srcSel = nextIsWide ? SRC_INC3 : SRC_INC2;
            strobes.cycles = nextIsWide ? CYC_W'(3) : CYC_W'(2);
          end
        end
        CC_RET: begin
          strobes.srcSel = SRC_STACK;
          strobes.cycles = CYC_W'(4);
        end
        CC_RETI: begin
          strobes.srcSel = SRC_STACK;
          strobes.cycles = CYC_W'(4);
          strobes.setI   = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nextpc_dp.sv
module nextpc_dp
  import nextpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int JOFF_W = 12,
  parameter int BOFF_W = 7
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               issue,
  input  ctrlStrobesT        strobes,
  input  logic [PC_W-1:0]    curPc,
  input  logic [JOFF_W-1:0]  offsetRaw,
  input  logic [PC_W-1:0]    zPtr,
  input  logic [PC_W-1:0]    stackPc,
  output logic [PC_W-1:0]    nextPc,
  output logic [CYC_W-1:0]   cycleCount,
  output logic               setIntFlag,
  output logic               outValid
);

  localparam int NUM_INC = 3;

  logic [PC_W-1:0] jmpExt;
  logic [PC_W-1:0] brExt;
  logic [PC_W-1:0] incCand [NUM_INC];
  logic [PC_W-1:0] jrelCand;
  logic [PC_W-1:0] brelCand;
  logic [PC_W-1:0] chosen;

  assign jmpExt = {{(PC_W-JOFF_W){offsetRaw[JOFF_W-1]}}, offsetRaw};
  assign brExt  = {{(PC_W-BOFF_W){offsetRaw[BOFF_W-1]}}, offsetRaw[BOFF_W-1:0]};

  // fixed forward steps of one, two and three words
  for (genvar s = 0; s < NUM_INC; s++) begin : g_inc
    assign incCand[s] = curPc + PC_W'(s + 1);
  end

  assign jrelCand = incCand[0] + jmpExt;
  assign brelCand = incCand[0] + brExt;

  always_comb begin
    case (strobes.srcSel)
      SRC_INC2:  chosen = incCand[1];
      SRC_INC3:  chosen = incCand[2];
      SRC_JREL:  chosen = jrelCand;
      SRC_BREL:  chosen = brelCand;
      SRC_PTR:   chosen = zPtr;
      SRC_STACK: chosen = stackPc;
      default:   chosen = incCand[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc     <= '0;
      cycleCount <= '0;
      setIntFlag <= 1'b0;
      outValid   <= 1'b0;
    end else if (issue) begin
      nextPc     <= chosen;
      cycleCount <= strobes.cycles;
      setIntFlag <= strobes.setI;
      outValid   <= 1'b1;
    end else begin
      outValid   <= 1'b0;
    end
  end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int JOFF_W = 12,
  parameter int BOFF_W = 7
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               issue,
  input  logic [3:0]         ctrlClass,
  input  logic [PC_W-1:0]    curPc,
  input  logic [JOFF_W-1:0]  offsetRaw,
  input  logic [7:0]         statusReg,
  input  logic [2:0]         bitSel,
  input  logic               cmpHit,
  input  logic               nextIsWide,
  input  logic [PC_W-1:0]    zPtr,
  input  logic [PC_W-1:0]    stackPc,
  output logic [PC_W-1:0]    nextPc,
  output logic [2:0]         cycleCount,
  output logic               setIntFlag,
  output logic               outValid
);

  ctrlStrobesT strobes;

  nextpc_ctrl u_ctrl (
    .ctrlClass  (ctrlClass),
    .statusReg  (statusReg),
    .bitSel     (bitSel),
    .cmpHit     (cmpHit),
    .nextIsWide (nextIsWide),
    .strobes    (strobes)
  );

  nextpc_dp #(
    .PC_W   (PC_W),
    .JOFF_W (JOFF_W),
    .BOFF_W (BOFF_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .issue      (issue),
    .strobes    (strobes),
    .curPc      (curPc),
    .offsetRaw  (offsetRaw),
    .zPtr       (zPtr),
    .stackPc    (stackPc),
    .nextPc     (nextPc),
    .cycleCount (cycleCount),
    .setIntFlag (setIntFlag),
    .outValid   (outValid)
  );

endmodule

// File: rtl/nextpc_chk.sv
module nextpc_chk #(
  parameter int PC_W = 16
)(
  input logic             clk,
  input logic             rstN,
  input logic             issue,
  input logic [3:0]       ctrlClass,
  input logic [PC_W-1:0]  curPc,
  input logic [7:0]       statusReg,
  input logic [2:0]       bitSel,
  input logic             cmpHit,
  input logic             nextIsWide,
  input logic [PC_W-1:0]  zPtr,
  input logic [PC_W-1:0]  stackPc,
  input logic [PC_W-1:0]  nextPc,
  input logic [2:0]       cycleCount,
  input logic             setIntFlag,
  input logic             outValid
);

  p_ind_jump_r3: assert property (@(posedge clk) disable iff (!rstN)
    issue && ctrlClass == 4'd3 |=> nextPc == $past(zPtr) && cycleCount == 3'd2);

  p_br_not_taken_r4: assert property (@(posedge clk) disable iff (!rstN)
    issue && ctrlClass == 4'd5 && !statusReg[bitSel]
      |=> nextPc == PC_W'($past(curPc) + 1) && cycleCount == 3'd1);

  p_skip_wide_r6: assert property (@(posedge clk) disable iff (!rstN)
    issue && ctrlClass == 4'd9 && cmpHit && nextIsWide
      |=> nextPc == PC_W'($past(curPc) + 3) && cycleCount == 3'd3);

  p_return_r7: assert property (@(posedge clk) disable iff (!rstN)
    issue && (ctrlClass == 4'd10 || ctrlClass == 4'd11)
      |=> nextPc == $past(stackPc) && cycleCount == 3'd4
          && setIntFlag == ($past(ctrlClass) == 4'd11));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> !outValid && $stable(nextPc) && $stable(cycleCount) && $stable(setIntFlag));

  p_issue_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    issue |=> outValid && cycleCount != 3'd0);

endmodule

bind nextpc_unit nextpc_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_nextpc_unit.sv
`timescale 1ns/1ps
module sim_nextpc_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issue;
  logic [3:0]  ctrlClass;
  logic [15:0] curPc;
  logic [11:0] offsetRaw;
  logic [7:0]  statusReg;
  logic [2:0]  bitSel;
  logic        cmpHit;
  logic        nextIsWide;
  logic [15:0] zPtr;
  logic [15:0] stackPc;
  logic [15:0] nextPc;
  logic [2:0]  cycleCount;
  logic        setIntFlag;
  logic        outValid;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nextpc_unit u0 (.*);

  // behavioural reference model
  logic [15:0] mPc;
  logic [2:0]  mCyc;
  logic        mI;
  logic        mV;
  string       mTag;

  always @(posedge clk) begin
    int    pc, cyc, off;
    bit    taken, si;
    string tag;
    if (!rstN) begin
      mPc <= 0; mCyc <= 0; mI <= 0; mV <= 0; mTag <= "R9";
    end else if (!issue) begin
      mV <= 0; mTag <= "R8";
    end else begin
      pc = curPc + 1; cyc = 1; si = 0; tag = "R1"; taken = 0;
      case (ctrlClass)
        1, 2: begin
          off = offsetRaw[11] ? int'(offsetRaw) - 4096 : int'(offsetRaw);
          pc = curPc + off + 1; cyc = (ctrlClass == 1) ? 2 : 3; tag = "R2";
        end
        3, 4: begin pc = zPtr; cyc = (ctrlClass == 3) ? 2 : 3; tag = "R3"; end
        5, 6, 7, 8: begin
          if (ctrlClass == 5) begin taken = statusReg[bitSel];  tag = "R4"; end
          if (ctrlClass == 6) begin taken = !statusReg[bitSel]; tag = "R4"; end
          if (ctrlClass == 7) begin taken = (statusReg[2] == statusReg[3]); tag = "R5"; end
          if (ctrlClass == 8) begin taken = (statusReg[2] != statusReg[3]); tag = "R5"; end
          if (taken) begin
            off = offsetRaw[6] ? int'(offsetRaw[6:0]) - 128 : int'(offsetRaw[6:0]);
            pc = curPc + off + 1; cyc = 2;
          end
        end
        9: begin
          tag = "R6";
          if (cmpHit) begin pc = curPc + (nextIsWide ? 3 : 2); cyc = nextIsWide ? 3 : 2; end
        end
        10, 11: begin pc = stackPc; cyc = 4; si = (ctrlClass == 11); tag = "R7"; end
        12, 13, 14, 15: tag = "R10";
        default: ;
      endcase
      if (nextIsWide && !(ctrlClass == 9 && cmpHit)) tag = {tag, "/R11"};
      mPc <= 16'(pc); mCyc <= 3'(cyc); mI <= si; mV <= 1; mTag <= tag;
    end
  end

  task automatic compareNow();
    checks++;
    if (nextPc !== mPc || cycleCount !== mCyc || setIntFlag !== mI || outValid !== mV) begin
      fails++;
      $display("FAIL %s: actual pc=%h cyc=%0d i=%b v=%b expected pc=%h cyc=%0d i=%b v=%b",
               mTag, nextPc, cycleCount, setIntFlag, outValid, mPc, mCyc, mI, mV);
    end
  endtask

  task automatic apply(input bit iss, input int cls, input int pc, input int off,
                       input int sr, input int bs, input bit hit, input bit wide,
                       input int z, input int stk);
    @(negedge clk);
    compareNow();
    issue = iss; ctrlClass = 4'(cls); curPc = 16'(pc); offsetRaw = 12'(off);
    statusReg = 8'(sr); bitSel = 3'(bs); cmpHit = hit; nextIsWide = wide;
    zPtr = 16'(z); stackPc = 16'(stk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still active expected finished");
    finishRun();
  end

  initial begin
    rstN = 0;
    issue = 0; ctrlClass = 0; curPc = 0; offsetRaw = 0; statusReg = 0;
    bitSel = 0; cmpHit = 0; nextIsWide = 0; zPtr = 0; stackPc = 0;
    // R9: reset holds outputs at zero even with issue active
    apply(1, 11, 16'h1234, 0, 0, 0, 0, 0, 16'h5555, 16'hAAAA);
    apply(1, 2, 16'h0100, 12'h7FF, 0, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rstN = 1;
    // R1: sequential step and wrap
    apply(1, 0, 16'h0010, 0, 0, 0, 0, 0, 0, 0);
    apply(1, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    // R2: relative jump forward, backward, and call with wrap
    apply(1, 1, 16'h0100, 12'h010, 0, 0, 0, 0, 0, 0);
    apply(1, 1, 16'h0100, 12'hFFF, 0, 0, 0, 0, 0, 0);
    apply(1, 2, 16'h0005, 12'h800, 0, 0, 0, 0, 0, 0);
    // R3: indirect jump and call
    apply(1, 3, 16'h0200, 0, 0, 0, 0, 0, 16'hBEEF, 0);
    apply(1, 4, 16'h0200, 0, 0, 0, 0, 0, 16'h0042, 0);
    // R4: bit-set / bit-clear branches, upper offset bits ignored
    apply(1, 5, 16'h0300, 12'hA40, 8'h02, 1, 0, 0, 0, 0);
    apply(1, 5, 16'h0300, 12'hA40, 8'hFD, 1, 0, 0, 0, 0);
    apply(1, 6, 16'h0300, 12'h03F, 8'h00, 7, 0, 0, 0, 0);
    apply(1, 6, 16'h0300, 12'h03F, 8'h80, 7, 0, 0, 0, 0);
    // R5: signed relations from N (bit 2) and V (bit 3), S ignored
    apply(1, 7, 16'h0400, 12'h005, 8'h0C, 0, 0, 0, 0, 0);
    apply(1, 7, 16'h0400, 12'h005, 8'h14, 0, 0, 0, 0, 0);
    apply(1, 8, 16'h0400, 12'h07E, 8'h08, 0, 0, 0, 0, 0);
    apply(1, 8, 16'h0400, 12'h07E, 8'h10, 0, 0, 0, 0, 0);
    // R6: skip, all combinations of hit and wide
    apply(1, 9, 16'h0500, 0, 0, 0, 0, 0, 0, 0);
    apply(1, 9, 16'h0500, 0, 0, 0, 0, 1, 0, 0);
    apply(1, 9, 16'h0500, 0, 0, 0, 1, 0, 0, 0);
    apply(1, 9, 16'hFFFE, 0, 0, 0, 1, 1, 0, 0);
    // R7: return then interrupt return back to back, then return again
    apply(1, 10, 16'h0600, 0, 0, 0, 0, 0, 0, 16'h1111);
    apply(1, 11, 16'h0600, 0, 0, 0, 0, 0, 0, 16'h2222);
    apply(1, 10, 16'h0600, 0, 0, 0, 0, 0, 0, 16'h3333);
    apply(1, 11, 16'h0600, 0, 0, 0, 0, 0, 0, 16'h4444);
    // R8: idle cycles hold the last result with valid low
    apply(0, 1, 16'h0700, 12'h123, 0, 0, 1, 1, 16'h9999, 16'h8888);
    apply(0, 3, 16'h0700, 0, 0, 0, 0, 0, 16'h9999, 0);
    // R10: unused class codes act as sequential
    for (int c = 12; c < 16; c++) apply(1, c, 16'h0800 + c, 12'hFFF, 8'hFF, 0, 1, 0, 16'h7777, 16'h6666);
    // R11: wide flag on non-skip classes
    apply(1, 1, 16'h0900, 12'h020, 0, 0, 0, 1, 0, 0);
    apply(1, 5, 16'h0900, 12'h020, 8'h01, 0, 1, 1, 0, 0);
    apply(1, 0, 16'h0900, 0, 0, 0, 1, 1, 0, 0);
    // mixed random traffic, R1..R11 judged by the model every clock
    for (int n = 0; n < 3000; n++)
      apply(($urandom % 5) != 0, $urandom % 16, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom, $urandom);
    // mid-run reset, R9
    rstN = 0;
    apply(1, 11, 16'h1000, 0, 0, 0, 0, 0, 0, 16'hFFFF);
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rstN = 1;
    apply(1, 9, 16'h1000, 0, 0, 0, 1, 1, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    finishRun();
  end

endmodule